// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This unit gathers event pulses from a memory-card host controller's bus engine and holds them in a sticky status register. Each implemented bit belongs to one of two groups. Nine completion events report that a response, a busy phase, a buffer step, a data transfer or an automatic stop-command phase has finished. Twelve error events report timeouts, response faults, data faults and protocol violations. An enable mask register with the same bit layout selects which status bits may raise the combined interrupt line. A separate error line is raised only by enabled bits of the error group.

Software reads either register through a simple register port. It clears status bits by writing a word in which each bit to be cleared is zero. Bits written as one are left unchanged. This lets a handler acknowledge one event without a read-modify-write. A soft reset input returns the whole unit to its reset state.

Top module: `irq_status_unit`

## Requirements
- R1: After rst_ni is released, the status register, the mask register, irq_o and err_o all read zero.
- R2: A one on evt_i at an implemented position sets that status bit at the next clock edge. The bit then stays set until it is cleared. Completion positions are 16, 17, 20, 21, 22, 23, 24, 25 and 26. Error positions are 0 to 5, 8 to 11, 14 and 15.
- R3: A write with wr_sel_i=0 (status) clears every status bit whose wr_data_i bit is 0. Status bits whose wr_data_i bit is 1 keep their value.
- R4: If an event and a zero-write hit the same status bit in the same cycle, the bit is set after the edge.
- R5: A write with wr_sel_i=1 (mask) loads the mask register with wr_data_i at the implemented positions. rd_sel_i=1 returns the mask and rd_sel_i=0 returns the status.
- R6: irq_o is registered. It is 1 exactly one cycle after a cycle in which some status bit and its mask bit are both 1.
- R7: err_o is registered. It is 1 exactly one cycle after a cycle in which some error-group status bit and its mask bit are both 1. Completion bits never drive it.
- R8: Positions that are not implemented (6, 7, 12, 13, 18, 19 and 27 to 31) read as zero in both registers. Events and writes at these positions have no effect.
- R9: soft_rst_i clears status, mask, irq_o and err_o at the next clock edge, overriding events and writes.
- R10: Writing 0xD80430C0 to the status register clears every implemented status bit, because that word has no implemented position set.
- R11: Reading either register has no side effect on the status or mask contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous clear of the whole unit |
| evt_i | input | 32 | Event pulses from the card bus engine, one per status bit |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 status, 1 mask |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 1 | Read source: 0 status, 1 mask |
| rd_data_o | output | 32 | Read data, combinational from the registers |
| irq_o | output | 1 | Combined enabled-event interrupt |
| err_o | output | 1 | Enabled error-group summary |

## Verification
Suppose a status flop holds a wrong value: it missed a set, it lost a clear, or it ignored the set-over-clear rule. The wrong value then appears on rd_data_o in the cycle straight after the edge. If the bit is enabled, irq_o and possibly err_o go wrong one cycle later. A wrong mask value shows on readback at once, and on the interrupt lines only once a matching status bit is set. The bench therefore reads both registers after every edge and compares both lines against a model. Any divergence is caught within one or two cycles of its cause.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int unsigned DATA_W = 32;

  // completion group: rsp, busy, rd-ready, wr-ready, rd-done, xfer-done, stop-rsp, stop-busy, stop-data
  localparam logic [DATA_W-1:0] CMPL_BITS =
    (32'd1 << 16) | (32'd1 << 17) | (32'd1 << 20) | (32'd1 << 21) | (32'd1 << 22) |
    (32'd1 << 23) | (32'd1 << 24) | (32'd1 << 25) | (32'd1 << 26);

  // error group: timeouts 0..5, response/data faults 8..11, violations 14..15
  localparam logic [DATA_W-1:0] ERR_BITS =
    (32'h3F) | (32'hF << 8) | (32'h3 << 14);

  localparam logic [DATA_W-1:0] VALID_BITS = CMPL_BITS | ERR_BITS;

  typedef enum logic {SEL_STATUS = 1'b0, SEL_MASK = 1'b1} reg_sel_e;
endpackage

// File: rtl/evt_status_bank.sv
module evt_status_bank #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         soft_clr_i,
  input  logic [W-1:0] evt_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_word_i,
  output logic [W-1:0] status_o
);
  for (genvar k = 0; k < W; k++) begin : g_bit
    if (VALID[k]) begin : g_impl
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         q <= 1'b0;
        else if (soft_clr_i) q <= 1'b0;
        else if (evt_i[k])   q <= 1'b1;  // set beats clear
        else if (clr_we_i && !clr_word_i[k]) q <= 1'b0;
      end
      assign status_o[k] = q;

      // R4
      set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_i[k] && !soft_clr_i) |=> status_o[k]);
      // R3
      zero_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_we_i && !clr_word_i[k] && !evt_i[k]) |=> !status_o[k]);
      // R11
      sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!soft_clr_i && !evt_i[k] && !(clr_we_i && !clr_word_i[k])) |=> $stable(status_o[k]));
    end else begin : g_none
      assign status_o[k] = 1'b0;
    end
  end

  logic unused_bits;
  assign unused_bits = ^((evt_i | clr_word_i) & ~VALID);

  // R9
  soft_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_clr_i |=> (status_o == '0));
endmodule

// File: rtl/mask_reg.sv
module mask_reg #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         soft_clr_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         q <= '0;
    else if (soft_clr_i) q <= '0;
    else if (we_i)       q <= wdata_i & VALID;
  end
  assign mask_o = q;

  // R8
  mask_unimpl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !soft_clr_i) |=> ((mask_o & ~VALID) == '0));
  // R5
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !soft_clr_i) |=> $stable(mask_o));
endmodule

// File: rtl/irq_reduce.sv
module irq_reduce #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] ERR = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         soft_clr_i,
  input  logic [W-1:0] status_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_o,
  output logic         err_o
);
  logic [W-1:0] live;
  assign live = status_i & mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o <= 1'b0;
      err_o <= 1'b0;
    end else if (soft_clr_i) begin
      irq_o <= 1'b0;
      err_o <= 1'b0;
    end else begin
      irq_o <= |live;
      err_o <= |(live & ERR);
    end
  end

  // R7
  err_implies_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> irq_o);
  // R6
  irq_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !soft_clr_i |=> (irq_o == $past(|(status_i & mask_i))));
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_status_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic [DATA_W-1:0] evt_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o,
  output logic              err_o
);
  logic [DATA_W-1:0] status, mask;
  logic st_we, mk_we;

  assign st_we = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_STATUS);
  assign mk_we = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_MASK);

  evt_status_bank #(.W(DATA_W), .VALID(VALID_BITS)) i_status (
    .clk_i, .rst_ni, .soft_clr_i(soft_rst_i), .evt_i,
    .clr_we_i(st_we), .clr_word_i(wr_data_i), .status_o(status));

  mask_reg #(.W(DATA_W), .VALID(VALID_BITS)) i_mask (
    .clk_i, .rst_ni, .soft_clr_i(soft_rst_i), .we_i(mk_we),
    .wdata_i(wr_data_i), .mask_o(mask));

  irq_reduce #(.W(DATA_W), .ERR(ERR_BITS)) i_reduce (
    .clk_i, .rst_ni, .soft_clr_i(soft_rst_i), .status_i(status),
    .mask_i(mask), .irq_o, .err_o);

  assign rd_data_o = (reg_sel_e'(rd_sel_i) == SEL_MASK) ? mask : status;

  // R8
  status_unimpl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status & ~VALID_BITS) == '0));
  // R1
  reset_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!irq_o && !err_o));
endmodule

// File: tb/test_irq_status_unit.sv
module test_irq_status_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_ni = 0, soft_rst = 0, wr_en = 0, wr_sel = 0, rd_sel = 0;
  logic [31:0] evt = 0, wr_data = 0, rd_data;
  logic irq, err;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_unit i_irq_status_unit (
    .clk_i(clk), .rst_ni(rst_ni), .soft_rst_i(soft_rst), .evt_i(evt),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data), .irq_o(irq), .err_o(err));

  // reference model state
  logic [31:0] m_st = 0, m_mk = 0, cmpl = 0, errg = 0, valid;
  logic m_irq = 0, m_err = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    rd_sel = 0; #1 chk(tag, "status", rd_data, m_st);
    rd_sel = 1; #1 chk(tag, "mask", rd_data, m_mk);
    rd_sel = 0; #1 chk(tag, "status reread", rd_data, m_st);  // R11
    chk(tag, "irq", {31'd0, irq}, {31'd0, m_irq});
    chk(tag, "err", {31'd0, err}, {31'd0, m_err});
  endtask

  task automatic step(string tag, logic [31:0] e, logic we, logic sel,
                      logic [31:0] d, logic srst);
    logic n_irq, n_err;
    evt = e; wr_en = we; wr_sel = sel; wr_data = d; soft_rst = srst;
    @(posedge clk);
    n_irq = (m_st & m_mk) != 0;
    n_err = (m_st & m_mk & errg) != 0;
    if (srst) begin
      m_st = 0; m_mk = 0; m_irq = 0; m_err = 0;
    end else begin
      if (we && !sel) m_st = m_st & d;
      m_st = (m_st | e) & valid;
      if (we && sel) m_mk = d & valid;
      m_irq = n_irq; m_err = n_err;
    end
    @(negedge clk);
    evt = 0; wr_en = 0; wr_data = 0; soft_rst = 0;
    compare(tag);
  endtask

  initial begin
    int cpos[9] = '{16, 17, 20, 21, 22, 23, 24, 25, 26};
    int epos[12] = '{0, 1, 2, 3, 4, 5, 8, 9, 10, 11, 14, 15};
    logic [31:0] lfsr;
    foreach (cpos[i]) cmpl[cpos[i]] = 1'b1;
    foreach (epos[i]) errg[epos[i]] = 1'b1;
    valid = cmpl | errg;

    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    compare("R1");

    step("R5", 0, 1, 1, 32'hFFFF_FFFF, 0);           // R8 unimpl mask bits
    step("R2", 32'h0001_0000, 0, 0, 0, 0);           // response end
    step("R6", 0, 0, 0, 0, 0);                        // irq one cycle later
    step("R3", 0, 1, 0, ~32'h0001_0000, 0);
    step("R6", 0, 0, 0, 0, 0);
    step("R2", 32'h0420_0000, 0, 0, 0, 0);
    step("R4", 32'h0020_0000, 1, 0, 32'h0, 0);       // set wins vs clear-all
    step("R7", 32'h0000_0001, 0, 0, 0, 0);
    step("R7", 0, 0, 0, 0, 0);
    step("R5", 0, 1, 1, cmpl, 0);                      // errors disabled
    step("R7", 0, 0, 0, 0, 0);
    step("R8", 32'hF80C_30C0, 0, 0, 0, 0);           // unimplemented events
    step("R8", 0, 1, 0, 32'h0000_0000 | ~valid, 0);
    step("R2", 32'h0000_C000, 0, 0, 0, 0);
    step("R10", 0, 1, 0, 32'hD804_30C0, 0);
    step("R6", 0, 0, 0, 0, 0);
    step("R5", 0, 1, 1, errg, 0);
    step("R7", 32'h0000_0800, 0, 0, 0, 0);
    step("R9", 32'h0000_0004, 1, 1, 32'hFFFF_FFFF, 1);
    step("R9", 0, 0, 0, 0, 0);

    lfsr = 32'hACE1_2345;
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a, b;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      b = lfsr;
      step("R4", a & b & {32{a[3]}}, b[5], a[9], a ^ {b[15:0], b[31:16]},
           (a[20:14] == 7'd0));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule